// File: doc/BRIEF.md
# Parallel NOR flash write-command sequencer

This block interprets the write cycles that a host sends to an emulated parallel NOR flash. Each write carries an address, a data word and a size. The block walks a cycle-indexed state machine through the two-write unlock handshake, the command write and the argument writes that follow it. It then either programs the addressed bytes of a small internal byte array or starts an erase. Programming only clears bits: the new byte value is the old value ANDed with the written data. An erase sets bytes to 0xFF.

The current command code and cycle index go out as outputs, so a separate read path can tell array reads from identification or query reads. An erase raises a one-cycle start pulse toward an external status and timer unit. The sequencer then holds in its busy cycle until that unit reports completion. A fast mode removes the unlock handshake from repeated programming. A read-only input keeps the array frozen while commands are still decoded in full.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, cycle is 0, cmd_mode is 0x00, bypass is 0, erase_start is 0, and every array byte reads 0xFF.
- R2: A write with data byte 0xF0 returns the sequencer to cycle 0 with cmd_mode 0x00 and bypass 0, unless cmd_mode is 0xA0 (program pending). In that case the 0xF0 is programmed like any other data.
- R3: In cycle 0, data 0x98 at word offset 0x55 enters the query mode: cycle 7, cmd_mode 0x98. Data 0xAA at word offset UNLOCK0 moves to cycle 1. Any other write returns to cycle 0.
- R4: In cycle 1, data 0x55 at word offset UNLOCK1 moves to cycle 2. Any other write returns to cycle 0 with cmd_mode 0x00.
- R5: In cycle 2 the write must target word offset UNLOCK0, unless bypass is 1. Data 0x20 sets bypass and stays in cycle 2. Data 0x80, 0x90 or 0xA0 moves to cycle 3 with cmd_mode equal to the data. Any other value, or a wrong offset, returns to cycle 0.
- R6: In cycle 3 with cmd_mode 0xA0, the write ANDs 1, 2 or 4 bytes into the array (wr_size 0, 1, 2; 3 means 4 bytes). The bytes go at array index (wr_addr + k) modulo the array size. With big_endian 0, byte k takes data bits [8k+7:8k]. With big_endian 1, the byte at wr_addr takes the most significant of the written bytes. Afterwards the state is cycle 0, or cycle 2 with cmd_mode 0x00 if bypass is 1.
- R7: With cmd_mode 0x80 in cycle 3, the writes 0xAA at UNLOCK0 and 0x55 at UNLOCK1 lead to cycle 5. There, 0x10 at UNLOCK0 sets the whole array to 0xFF. Data 0x30 at any offset sets to 0xFF the sector that holds the addressed byte. Either one sets cycle 6 and cmd_mode to the data, and pulses erase_start for exactly one cycle: erase_chip is 1 for 0x10 and 0 for 0x30. Any other write in cycle 5 returns to cycle 0.
- R8: In cycle 6, writes other than 0xF0 leave the cycle, cmd_mode and the array unchanged. erase_done returns to cycle 0, or to cycle 2 if bypass is 1, with cmd_mode 0x00.
- R9: In cycle 3 with cmd_mode 0x90, data 0x98 at word offset 0x55 enters the query mode (cycle 7, cmd_mode 0x98). If bypass is 1, data 0x00 clears bypass and returns to cycle 0.
- R10: Any write in cycle 7 returns to cycle 0 with cmd_mode 0x00.
- R11: While read_only is 1, programming and erasing leave the array unchanged. The cycle, cmd_mode and erase_start behave as they would with read_only at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A write cycle is present this clock |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8*MAX_BYTES | Write data; the low byte is the command code |
| wr_size | input | 2 | Write size: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes |
| big_endian | input | 1 | Byte order used when programming |
| read_only | input | 1 | Blocks every array change |
| erase_done | input | 1 | The external timer reports that the erase has finished |
| rd_addr | input | IDX_W | Array index for the read port |
| rd_byte | output | 8 | Array byte at rd_addr (combinational) |
| cmd_mode | output | 8 | Current command code |
| cycle | output | 3 | Current write-cycle index |
| bypass | output | 1 | Fast (unlock-skipping) mode active |
| erase_start | output | 1 | One-cycle pulse when an erase begins |
| erase_chip | output | 1 | Kind of the last erase: 1 is whole array, 0 is one sector |

## Verification
Every write is taken at one rising edge. The cycle, cmd_mode, bypass and erase_chip outputs, and the array bytes seen on rd_byte, all change at that same edge. erase_start is high for exactly the one cycle after the edge that accepts the erase select write. The bench drives each write on a falling edge and drops wr_en at the next falling edge. It then samples the state and erase_start at that falling edge, which is after the accepting edge and before the following one. Array contents are read through rd_addr after a short settle delay, and are compared against a model that applies AND programming and sector-sized erases.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_UNLK1 = 3'd1,
    CYC_CMD   = 3'd2,
    CYC_ARG   = 3'd3,
    CYC_UNLK2 = 3'd4,
    CYC_ERSEL = 3'd5,
    CYC_BUSY  = 3'd6,
    CYC_QUERY = 3'd7
  } cyc_e;

  localparam logic [7:0] D_ABORT  = 8'hF0;
  localparam logic [7:0] D_KEY0   = 8'hAA;
  localparam logic [7:0] D_KEY1   = 8'h55;
  localparam logic [7:0] D_QUERY  = 8'h98;
  localparam logic [7:0] D_FAST   = 8'h20;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_IDENT  = 8'h90;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_NONE   = 8'h00;
  localparam int         QUERY_OFF = 'h55;

  typedef struct packed {
    cyc_e       cyc;
    logic [7:0] cmd;
    logic       byp;
  } seq_t;

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int UNLOCK0 = 'h555,
  parameter int UNLOCK1 = 'h2AA
) (
  input  seq_t             cur,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       din,
  input  logic             erase_done,
  output seq_t             nxt,
  output logic             do_prog,
  output logic             do_chip,
  output logic             do_sect
);

  logic hit_u0, hit_u1, hit_q;
  seq_t idle_s, fast_s, done_s, key0_s;

  assign hit_u0 = (off == OFF_W'(UNLOCK0));
  assign hit_u1 = (off == OFF_W'(UNLOCK1));
  assign hit_q  = (off == OFF_W'(QUERY_OFF)) && (din == D_QUERY);

  always_comb begin
    idle_s = '{cyc: CYC_IDLE, cmd: D_NONE, byp: 1'b0};
    fast_s = '{cyc: CYC_CMD,  cmd: D_NONE, byp: 1'b1};
    done_s = cur.byp ? fast_s : idle_s;
    // first-key check, shared by cycle 0 and the second unlock of an erase
    if (hit_q)
      key0_s = '{cyc: CYC_QUERY, cmd: D_QUERY, byp: cur.byp};
    else if (hit_u0 && din == D_KEY0)
      key0_s = '{cyc: cyc_e'(cur.cyc + 3'd1), cmd: cur.cmd, byp: cur.byp};
    else
      key0_s = idle_s;
  end

  always_comb begin
    nxt     = cur;
    do_prog = 1'b0;
    do_chip = 1'b0;
    do_sect = 1'b0;
    if (wr_en) begin
      if (cur.cmd != D_PROG && din == D_ABORT) begin
        nxt = idle_s;
      end else begin
        unique case (cur.cyc)
          CYC_IDLE:  nxt = key0_s;
          CYC_UNLK1: nxt = (hit_u1 && din == D_KEY1) ?
                           '{cyc: CYC_CMD, cmd: cur.cmd, byp: cur.byp} : idle_s;
          CYC_CMD: begin
            if (!cur.byp && !hit_u0) nxt = idle_s;
            else if (din == D_FAST) nxt = fast_s;
            else if (din == D_ERASE || din == D_IDENT || din == D_PROG)
              nxt = '{cyc: CYC_ARG, cmd: din, byp: cur.byp};
            else nxt = idle_s;
          end
          CYC_ARG: begin
            if (cur.cmd == D_ERASE) nxt = key0_s;
            else if (cur.cmd == D_PROG) begin
              do_prog = 1'b1;
              nxt     = done_s;
            end else if (cur.cmd == D_IDENT && hit_q && !(cur.byp && din == D_NONE))
              nxt = '{cyc: CYC_QUERY, cmd: D_QUERY, byp: cur.byp};
            else nxt = idle_s;
          end
          CYC_UNLK2: nxt = (cur.cmd == D_ERASE && hit_u1 && din == D_KEY1) ?
                           '{cyc: CYC_ERSEL, cmd: cur.cmd, byp: cur.byp} : idle_s;
          CYC_ERSEL: begin
            if (din == D_CHIP && hit_u0) begin
              do_chip = 1'b1;
              nxt     = '{cyc: CYC_BUSY, cmd: din, byp: cur.byp};
            end else if (din == D_SECT) begin
              do_sect = 1'b1;
              nxt     = '{cyc: CYC_BUSY, cmd: din, byp: cur.byp};
            end else nxt = idle_s;
          end
          CYC_BUSY:  nxt = erase_done ? done_s : cur;
          CYC_QUERY: nxt = idle_s;
          default:   nxt = idle_s;
        endcase
      end
    end else if (cur.cyc == CYC_BUSY && erase_done) begin
      nxt = done_s;
    end
  end

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int SECTOR_BYTES = 16,
  parameter int NUM_SECTORS  = 4,
  parameter int MAX_BYTES    = 4,
  localparam int NUM_BYTES   = SECTOR_BYTES * NUM_SECTORS,
  localparam int IDX_W       = $clog2(NUM_BYTES),
  localparam int SOFF_W      = $clog2(SECTOR_BYTES),
  localparam int LANE_W      = $clog2(MAX_BYTES),
  localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog,
  input  logic                   chip,
  input  logic                   sect,
  input  logic [IDX_W-1:0]       base,
  input  logic [8*MAX_BYTES-1:0] data,
  input  logic [CNT_W-1:0]       nbytes,
  input  logic                   big_endian,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [7:0]             rd_byte
);

  logic [8*NUM_BYTES-1:0] rd_flat;
  logic [LANE_W-1:0]      top_lane;

  assign top_lane = LANE_W'(nbytes - CNT_W'(1));

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic [IDX_W-1:0]  lane;
    logic [LANE_W-1:0] sel;
    logic [7:0]        pbyte, mem_d, mem_q;
    logic              hit, ers, en;

    assign lane  = MY_IDX - base;
    assign hit   = prog && (lane < IDX_W'(nbytes));
    assign sel   = big_endian ? (top_lane - lane[LANE_W-1:0]) : lane[LANE_W-1:0];
    assign pbyte = data[{sel, 3'b000} +: 8];
    assign ers   = chip || (sect && (MY_IDX[IDX_W-1:SOFF_W] == base[IDX_W-1:SOFF_W]));
    assign en    = ers || hit;

    always_comb begin
      if (ers) mem_d = 8'hFF;
      else     mem_d = mem_q & pbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q <= 8'hFF;
      else if (en) mem_q <= mem_d;
    end

    assign rd_flat[8*i +: 8] = mem_q;
  end

  assign rd_byte = rd_flat[{rd_idx, 3'b000} +: 8];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BUS_BYTES    = 1,
  parameter int SECTOR_BYTES = 16,
  parameter int NUM_SECTORS  = 4,
  parameter int MAX_BYTES    = 4,
  parameter int UNLOCK0      = 'h555,
  parameter int UNLOCK1      = 'h2AA,
  localparam int NUM_BYTES   = SECTOR_BYTES * NUM_SECTORS,
  localparam int IDX_W       = $clog2(NUM_BYTES),
  localparam int WSHIFT      = $clog2(BUS_BYTES),
  localparam int OFF_W       = ADDR_W - WSHIFT,
  localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [8*MAX_BYTES-1:0] wr_data,
  input  logic [1:0]             wr_size,
  input  logic                   big_endian,
  input  logic                   read_only,
  input  logic                   erase_done,
  input  logic [IDX_W-1:0]       rd_addr,
  output logic [7:0]             rd_byte,
  output logic [7:0]             cmd_mode,
  output logic [2:0]             cycle,
  output logic                   bypass,
  output logic                   erase_start,
  output logic                   erase_chip
);

  seq_t             seq_q, seq_d;
  logic             do_prog, do_chip, do_sect;
  logic             start_q, chip_q;
  logic [CNT_W-1:0] nbytes;

  always_comb begin
    unique case (wr_size)
      2'd0:    nbytes = CNT_W'(1);
      2'd1:    nbytes = CNT_W'(2);
      default: nbytes = CNT_W'(MAX_BYTES);
    endcase
  end

  flash_seq_decode #(
    .OFF_W(OFF_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
  ) u_dec (
    .cur(seq_q), .wr_en(wr_en), .off(wr_addr[ADDR_W-1:WSHIFT]),
    .din(wr_data[7:0]), .erase_done(erase_done),
    .nxt(seq_d), .do_prog(do_prog), .do_chip(do_chip), .do_sect(do_sect)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= '{cyc: CYC_IDLE, cmd: D_NONE, byp: 1'b0};
      start_q <= 1'b0;
      chip_q  <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      start_q <= do_chip || do_sect;
      if (do_chip || do_sect) chip_q <= do_chip;
    end
  end

  flash_byte_array #(
    .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS), .MAX_BYTES(MAX_BYTES)
  ) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog(do_prog && !read_only), .chip(do_chip && !read_only),
    .sect(do_sect && !read_only), .base(wr_addr[IDX_W-1:0]),
    .data(wr_data), .nbytes(nbytes), .big_endian(big_endian),
    .rd_idx(rd_addr), .rd_byte(rd_byte)
  );

  assign cmd_mode    = seq_q.cmd;
  assign cycle       = seq_q.cyc;
  assign bypass      = seq_q.byp;
  assign erase_start = start_q;
  assign erase_chip  = chip_q;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int WSHIFT = 0,
  parameter int IDX_W  = 6,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              read_only,
  input logic              erase_done,
  input logic [IDX_W-1:0]  rd_addr,
  input logic [7:0]        rd_byte,
  input logic [7:0]        cmd_mode,
  input logic [2:0]        cycle,
  input logic              bypass,
  input logic              erase_start
);

  logic [7:0] d8;
  logic       at_q;
  assign d8   = wr_data[7:0];
  assign at_q = (wr_addr[ADDR_W-1:WSHIFT] == (ADDR_W-WSHIFT)'('h55));

  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && d8 == 8'hF0 && cmd_mode != 8'hA0) |=> (cycle == 3'd0 && !bypass && cmd_mode == 8'h00));

  p_query_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cycle == 3'd0 && at_q && d8 == 8'h98) |=> (cycle == 3'd7 && cmd_mode == 8'h98));

  p_second_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cycle == 3'd1 && d8 != 8'h55) |=> (cycle == 3'd0));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (cycle == 3'd6));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle == 3'd6 && wr_en && d8 != 8'hF0 && !erase_done) |=> (cycle == 3'd6 && $stable(cmd_mode)));

  p_query_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle == 3'd7 && wr_en) |=> (cycle == 3'd0 && cmd_mode == 8'h00));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (read_only && $past(read_only) && $stable(rd_addr)) |-> $stable(rd_byte));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .WSHIFT(WSHIFT), .IDX_W(IDX_W), .DW(8*MAX_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .read_only(read_only), .erase_done(erase_done), .rd_addr(rd_addr),
  .rd_byte(rd_byte), .cmd_mode(cmd_mode), .cycle(cycle), .bypass(bypass),
  .erase_start(erase_start)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;

  localparam int NB = 64;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, big_endian, read_only, erase_done;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  wr_size;
  logic [5:0]  rd_addr;
  logic [7:0]  rd_byte, cmd_mode;
  logic [2:0]  cycle;
  logic        bypass, erase_start, erase_chip;

  always #4 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .big_endian(big_endian), .read_only(read_only),
    .erase_done(erase_done), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .cmd_mode(cmd_mode), .cycle(cycle), .bypass(bypass),
    .erase_start(erase_start), .erase_chip(erase_chip)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NB];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int cyc, input int cmd, input int byp);
    chk({tag, " cycle"},  32'(cycle),    32'(cyc));
    chk({tag, " cmd"},    32'(cmd_mode), 32'(cmd));
    chk({tag, " bypass"}, 32'(bypass),   32'(byp));
  endtask

  task automatic chk_array(input string tag);
    int bad = 0;
    int first = -1;
    logic [7:0] got = 8'h00;
    for (int i = 0; i < NB; i++) begin
      rd_addr = 6'(i);
      #1;
      if (rd_byte !== model[i]) begin
        if (bad == 0) begin first = i; got = rd_byte; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s array index %0d actual=%0h expected=%0h (%0d bytes differ)",
               tag, first, got, model[first], bad);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd0);
    wr_addr = a; wr_data = d; wr_size = sz; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 32'hAA);
    wr(12'h2AA, 32'h55);
  endtask

  task automatic pulse_done();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  task automatic model_prog(input int a, input logic [31:0] d, input int sz, input bit be);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = be ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
      model[(a + k) % NB] = model[(a + k) % NB] & b;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_size = '0;
    big_endian = 1'b0; read_only = 1'b0; erase_done = 1'b0; rd_addr = '0;
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_state("R1 reset", 0, 8'h00, 0);
    chk("R1 erase_start", 32'(erase_start), 0);
    chk_array("R1 erased array");

    // R3 query entry, R10 exit
    wr(12'h055, 32'h98);
    chk_state("R3 query entry", 7, 8'h98, 0);
    wr(12'h321, 32'h12);
    chk_state("R10 query exit", 0, 8'h00, 0);

    // R3 bad and good first key
    wr(12'h555, 32'hAB);
    chk_state("R3 bad key", 0, 8'h00, 0);
    wr(12'h554, 32'hAA);
    chk_state("R3 bad offset", 0, 8'h00, 0);
    wr(12'h555, 32'hAA);
    chk_state("R3 good key", 1, 8'h00, 0);

    // R4
    wr(12'h2AB, 32'h55);
    chk_state("R4 bad offset", 0, 8'h00, 0);
    unlock();
    chk_state("R4 unlocked", 2, 8'h00, 0);

    // R5
    wr(12'h554, 32'hA0);
    chk_state("R5 wrong offset", 0, 8'h00, 0);
    unlock();
    wr(12'h555, 32'h77);
    chk_state("R5 unknown command", 0, 8'h00, 0);
    unlock();
    wr(12'h555, 32'h90);
    chk_state("R5 ident select", 3, 8'h90, 0);
    wr(12'h055, 32'h98);
    chk_state("R9 query from ident", 7, 8'h98, 0);
    wr(12'h000, 32'h00);
    chk_state("R10 exit", 0, 8'h00, 0);

    // R2 abort
    unlock();
    wr(12'h123, 32'hF0);
    chk_state("R2 abort in cycle 2", 0, 8'h00, 0);
    unlock();
    wr(12'h555, 32'h90);
    wr(12'h000, 32'hF0);
    chk_state("R2 abort in ident", 0, 8'h00, 0);

    // R6 normal program, R2 exception
    unlock();
    wr(12'h555, 32'hA0);
    chk_state("R5 program select", 3, 8'hA0, 0);
    wr(12'h013, 32'h5A);
    model_prog('h013, 32'h5A, 0, 0);
    chk_state("R6 program return", 0, 8'h00, 0);
    chk_array("R6 single byte");
    unlock();
    wr(12'h555, 32'hA0);
    wr(12'h014, 32'hF0);
    model_prog('h014, 32'hF0, 0, 0);
    chk_state("R2 F0 programmed", 0, 8'h00, 0);
    chk_array("R2 F0 data in array");

    // R5 fast mode, R6 sweep over size, byte order and address
    unlock();
    wr(12'h555, 32'h20);
    chk_state("R5 bypass on", 2, 8'h00, 1);
    begin
      int k = 0;
      logic [11:0] addrs [4] = '{12'h000, 12'h01D, 12'h03E, 12'h0A7};
      for (int sz = 0; sz < 4; sz++) begin
        for (int be = 0; be < 2; be++) begin
          for (int ai = 0; ai < 4; ai++) begin
            logic [31:0] d = {~8'(k*37+1), ~8'(k*53+2), ~8'(k*11+5), ~8'(k*29+7)};
            big_endian = 1'(be);
            wr(12'h123, 32'hA0);
            wr(addrs[ai], d, 2'(sz));
            model_prog(int'(addrs[ai]), d, sz, 1'(be));
            chk_state($sformatf("R6 sweep %0d return", k), 2, 8'h00, 1);
            chk_array($sformatf("R6 sweep %0d size %0d be %0d", k, sz, be));
            k++;
          end
        end
      end
      big_endian = 1'b0;
    end
    wr(12'h100, 32'h90);
    chk_state("R9 bypass ident", 3, 8'h90, 1);
    wr(12'h100, 32'h00);
    chk_state("R9 bypass exit", 0, 8'h00, 0);

    // R11 read-only
    read_only = 1'b1;
    unlock();
    wr(12'h555, 32'hA0);
    wr(12'h020, 32'h00);
    chk_state("R11 program sequence", 0, 8'h00, 0);
    chk_array("R11 program suppressed");
    unlock();
    wr(12'h555, 32'h80);
    unlock();
    wr(12'h01A, 32'h30);
    chk("R11 erase_start", 32'(erase_start), 1);
    chk_state("R11 erase sequence", 6, 8'h30, 0);
    chk_array("R11 erase suppressed");
    pulse_done();
    read_only = 1'b0;

    // R7 sector erase, R8 busy hold
    unlock();
    wr(12'h555, 32'h80);
    chk_state("R7 erase select", 3, 8'h80, 0);
    unlock();
    chk_state("R7 second unlock", 5, 8'h80, 0);
    wr(12'h01A, 32'h30);
    for (int i = 16; i < 32; i++) model[i] = 8'hFF;
    chk("R7 sector erase_start", 32'(erase_start), 1);
    chk("R7 sector erase_chip", 32'(erase_chip), 0);
    chk_state("R7 sector busy", 6, 8'h30, 0);
    @(negedge clk);
    chk("R7 erase_start one cycle", 32'(erase_start), 0);
    chk_array("R7 sector erased");
    wr(12'h555, 32'hAA);
    wr(12'h000, 32'hA0);
    chk_state("R8 writes ignored", 6, 8'h30, 0);
    chk_array("R8 array untouched");
    pulse_done();
    chk_state("R8 erase done", 0, 8'h00, 0);

    // R7 chip erase, bad address
    unlock();
    wr(12'h555, 32'h80);
    unlock();
    wr(12'h554, 32'h10);
    chk_state("R7 chip erase bad offset", 0, 8'h00, 0);
    chk_array("R7 no erase on bad offset");
    unlock();
    wr(12'h555, 32'h80);
    unlock();
    wr(12'h555, 32'h10);
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    chk("R7 chip erase_start", 32'(erase_start), 1);
    chk("R7 chip erase_chip", 32'(erase_chip), 1);
    chk_state("R7 chip busy", 6, 8'h10, 0);
    chk_array("R7 chip erased");
    pulse_done();
    chk_state("R8 chip done", 0, 8'h00, 0);

    // R8 return to fast mode, R2 clears bypass
    unlock();
    wr(12'h555, 32'h20);
    wr(12'h234, 32'h80);
    unlock();
    wr(12'h030, 32'h30);
    chk_state("R8 bypass busy", 6, 8'h30, 1);
    pulse_done();
    chk_state("R8 bypass done", 2, 8'h00, 1);
    wr(12'h000, 32'hF0);
    chk_state("R2 abort clears bypass", 0, 8'h00, 0);

    summary();
    $finish;
  end

endmodule